// File: doc/BRIEF.md
# Interrupt Flag and Alarm Controller

This block holds the three event flags of a real-time clock (periodic tick, alarm match and update completed), the three matching interrupt enables, and the summary interrupt bit. From these it drives an active-low, open-drain interrupt request. The request is given as an output-enable: when it is 1, the pad pulls the line low.

When an update pulse arrives, the block compares the current hours, minutes and seconds bytes with the three alarm bytes. Any alarm byte whose two top bits are both set matches every value.

Software reads the flag byte through a read strobe. The byte it sees stays frozen for the whole read. The flags are cleared when the read starts. Any event that arrives while the read is open is held back and lands in the flags once the strobe drops.

Top module: `irq_flag_ctrl`

## Requirements
- R1: The flag byte `flag_o` has the summary bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3 to 0 always read 0.
- R2: Outside a read, the summary bit and `irq_oe_o` are both 1 exactly when some flag is 1 together with its enable. `en_o` bit 2 pairs with bit 6, bit 1 with bit 5, and bit 0 with bit 4.
- R3: A one-cycle event pulse sets its flag, and the flag shows on `flag_o` after the next clock edge, whatever the state of its enable.
- R4: While `rd_i` is high, `flag_o` holds the value it had when the read began. The flags and the summary bit are cleared from the first edge of the read, which releases `irq_oe_o`.
- R5: An event that arrives while `rd_i` is high does not show during the read. It appears in `flag_o` on the first clock edge after `rd_i` falls.
- R6: On an `update_evt_i` pulse the alarm flag is set when each of the hours, minutes and seconds bytes either equals its alarm byte or has an alarm byte with bits 7:6 equal to 2'b11. An alarm byte with top bits 2'b10 is compared exactly.
- R7: When all three alarm bytes are wildcards, every update pulse sets the alarm flag.
- R8: Every `update_evt_i` pulse sets the update flag. While `set_mode_i` is high, the update enable (`en_o` bit 0) is forced to 0, even against a write.
- R9: Writing an enable for a flag that is already set asserts `irq_oe_o` on the next clock edge.
- R10: An asynchronous reset clears the enables, all flags and the summary bit, and releases `irq_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| periodic_evt_i | input | 1 | One-cycle periodic tick |
| update_evt_i | input | 1 | One-cycle pulse marking the end of an update |
| sec_i | input | 8 | Current seconds byte |
| min_i | input | 8 | Current minutes byte |
| hour_i | input | 8 | Current hours byte |
| sec_alm_i | input | 8 | Seconds alarm byte |
| min_alm_i | input | 8 | Minutes alarm byte |
| hour_alm_i | input | 8 | Hours alarm byte |
| en_we_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 3 | New enables {periodic, alarm, update} |
| set_mode_i | input | 1 | Time-setting mode; holds the update enable clear |
| rd_i | input | 1 | Flag-byte read strobe, high for the whole read |
| en_o | output | 3 | Current enables {periodic, alarm, update} |
| flag_o | output | 8 | Flag byte as seen by a read |
| irq_oe_o | output | 1 | Pull-down enable for the open-drain request line |

## Verification
On every cycle, the assertions check four things:
- the request equals the OR of the enabled flags outside a read;
- the flag byte is stable while a read is held;
- each event pulse outside a read sets its flag;
- a full-wildcard alarm fires on every update, and time-setting mode clears the update enable.

Some behaviours are visible only over a sequence of operations, so the bench scenarios cover them:
- clearing at read start;
- holding back an event that arrives mid-read;
- exact and partial alarm matches, including the 2'b10 non-wildcard case;
- a late enable against a stale flag;
- reset in the middle of operation.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_SRC    = 3;  // periodic, alarm, update
  localparam int N_ALM    = 3;  // hours, minutes, seconds
  localparam int SRC_LSB  = 4;  // flags sit at bits 6:4
  localparam int SUM_BIT  = 7;
  localparam int IDX_PER  = 2;
  localparam int IDX_ALM  = 1;
  localparam int IDX_UPD  = 0;
endpackage

// File: rtl/irqc_alarm_cmp.sv
module irqc_alarm_cmp #(
  parameter int W = irqc_pkg::BYTE_W,
  parameter int N = irqc_pkg::N_ALM
) (
  input  logic [N-1:0][W-1:0] cur_i,
  input  logic [N-1:0][W-1:0] alm_i,
  output logic                hit_o
);
  logic [N-1:0] byte_hit;
  for (genvar g = 0; g < N; g++) begin : g_byte
    // top two bits set => wildcard
    assign byte_hit[g] = (&alm_i[g][W-1:W-2]) || (alm_i[g] == cur_i[g]);
  end
  assign hit_o = &byte_hit;
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = irqc_pkg::N_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic         rd_i,
  output logic [N:0]   view_o,
  output logic         irqf_o
);
  logic         rd_q;
  logic [N-1:0] flags_q, pend_q;
  logic [N:0]   snap_q;

  assign irqf_o = |(flags_q & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      flags_q <= '0;
      pend_q  <= '0;
      snap_q  <= '0;
    end else begin
      rd_q <= rd_i;
      if (rd_i && !rd_q) begin
        snap_q  <= {irqf_o, flags_q};
        flags_q <= '0;
        pend_q  <= evt_i;
      end else if (rd_i) begin
        pend_q  <= pend_q | evt_i;
      end else if (rd_q) begin
        flags_q <= pend_q | evt_i;
        pend_q  <= '0;
      end else begin
        flags_q <= flags_q | evt_i;
      end
    end
  end

  assign view_o = rd_q ? snap_q : {irqf_o, flags_q};
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              periodic_evt_i,
  input  logic              update_evt_i,
  input  logic [BYTE_W-1:0] sec_i,
  input  logic [BYTE_W-1:0] min_i,
  input  logic [BYTE_W-1:0] hour_i,
  input  logic [BYTE_W-1:0] sec_alm_i,
  input  logic [BYTE_W-1:0] min_alm_i,
  input  logic [BYTE_W-1:0] hour_alm_i,
  input  logic              en_we_i,
  input  logic [N_SRC-1:0]  en_wdata_i,
  input  logic              set_mode_i,
  input  logic              rd_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [BYTE_W-1:0] flag_o,
  output logic              irq_oe_o
);
  localparam int PAD_W = SRC_LSB;

  logic [N_SRC-1:0] en_q, evt;
  logic [N_SRC:0]   view;
  logic             alm_hit, irqf;

  irqc_alarm_cmp #(.W(BYTE_W), .N(N_ALM)) u_cmp (
    .cur_i ({hour_i, min_i, sec_i}),
    .alm_i ({hour_alm_i, min_alm_i, sec_alm_i}),
    .hit_o (alm_hit)
  );

  always_comb begin
    evt          = '0;
    evt[IDX_PER] = periodic_evt_i;
    evt[IDX_ALM] = update_evt_i & alm_hit;
    evt[IDX_UPD] = update_evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      if (set_mode_i) en_q[IDX_UPD] <= 1'b0;
    end
  end

  irqc_flag_bank #(.N(N_SRC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .en_i   (en_q),
    .rd_i   (rd_i),
    .view_o (view),
    .irqf_o (irqf)
  );

  assign en_o     = en_q;
  assign flag_o   = {view, {PAD_W{1'b0}}};
  assign irq_oe_o = irqf;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       periodic_evt_i,
  input logic       update_evt_i,
  input logic [7:0] sec_alm_i,
  input logic [7:0] min_alm_i,
  input logic [7:0] hour_alm_i,
  input logic       set_mode_i,
  input logic       rd_i,
  input logic [2:0] en_o,
  input logic [7:0] flag_o,
  input logic       irq_oe_o
);
  AST_IRQ_EQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !$past(rd_i)) |-> (irq_oe_o == |(flag_o[6:4] & en_o))); // R2

  AST_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $past(rd_i) && $past(rd_i, 2)) |-> $stable(flag_o)); // R4

  AST_PER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periodic_evt_i && !rd_i) |=> flag_o[6]); // R3

  AST_UPD_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_evt_i && !rd_i) |=> flag_o[4]); // R8

  AST_WILD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_evt_i && !rd_i && (&sec_alm_i[7:6]) && (&min_alm_i[7:6]) && (&hour_alm_i[7:6]))
      |=> flag_o[5]); // R7

  AST_SET_UIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_i |=> !en_o[0]); // R8
endmodule

bind irq_flag_ctrl irqc_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni),
  .periodic_evt_i (periodic_evt_i), .update_evt_i (update_evt_i),
  .sec_alm_i (sec_alm_i), .min_alm_i (min_alm_i), .hour_alm_i (hour_alm_i),
  .set_mode_i (set_mode_i), .rd_i (rd_i),
  .en_o (en_o), .flag_o (flag_o), .irq_oe_o (irq_oe_o)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic per = 0, upd = 0, we = 0, setm = 0, rd = 0;
  logic [2:0] wdata = '0;
  logic [7:0] sec = 0, mn = 0, hr = 0, sa = 8'h01, ma = 8'h01, ha = 8'h01;
  logic [2:0] en;
  logic [7:0] flg;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .periodic_evt_i(per), .update_evt_i(upd),
    .sec_i(sec), .min_i(mn), .hour_i(hr), .sec_alm_i(sa), .min_alm_i(ma),
    .hour_alm_i(ha), .en_we_i(we), .en_wdata_i(wdata), .set_mode_i(setm),
    .rd_i(rd), .en_o(en), .flag_o(flg), .irq_oe_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit p, input bit u);
    per = p; upd = u;
    @(negedge clk);
    per = 0; upd = 0;
  endtask

  task automatic wr_en(input logic [2:0] v);
    we = 1; wdata = v;
    @(negedge clk);
    we = 0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd = 1;
    @(negedge clk);
    v = flg;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(flg == v, "R4 stable", flg, v);
    end
    rd = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(flg == 8'h00, "R10 flags", flg, 0);
    chk(irq == 1'b0, "R10 irq", irq, 0);
    chk(en == 3'b000, "R10 en", en, 0);
  endtask

  task automatic t_poll;
    logic [7:0] v;
    pulse(1, 0);
    chk(flg == 8'h40, "R3 R1 periodic flag", flg, 8'h40);
    chk(irq == 0, "R3 no irq", irq, 0);
    do_read(v);
    chk(v == 8'h40, "R4 read value", v, 8'h40);
    chk(flg == 8'h00, "R4 cleared", flg, 0);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr_en(3'b100);
    pulse(1, 0);
    chk(flg == 8'hC0, "R2 R1 summary", flg, 8'hC0);
    chk(irq == 1, "R2 irq", irq, 1);
    rd = 1;
    @(negedge clk);
    chk(irq == 0, "R4 irq released", irq, 0);
    chk(flg == 8'hC0, "R4 snapshot", flg, 8'hC0);
    rd = 0;
    @(negedge clk);
    chk(flg == 8'h00, "R4 after read", flg, 0);
    wr_en(3'b000);
  endtask

  task automatic t_late_en;
    logic [7:0] v;
    pulse(0, 1);
    chk(flg == 8'h10, "R8 update flag", flg, 8'h10);
    chk(irq == 0, "R2 masked", irq, 0);
    wr_en(3'b001);
    chk(irq == 1, "R9 immediate irq", irq, 1);
    chk(flg == 8'h90, "R9 summary", flg, 8'h90);
    do_read(v);
    wr_en(3'b000);
  endtask

  task automatic t_defer;
    logic [7:0] v;
    rd = 1;
    @(negedge clk);
    v = flg;
    pulse(1, 0);
    chk(flg == v, "R5 hidden during read", flg, v);
    @(negedge clk);
    chk(flg == v, "R5 still hidden", flg, v);
    rd = 0;
    @(negedge clk);
    chk(flg == 8'h40, "R5 applied after read", flg, 8'h40);
    do_read(v);
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    hr = 8'h12; mn = 8'h34; sec = 8'h56;
    ha = 8'h12; ma = 8'h34; sa = 8'h56;
    pulse(0, 1);
    chk(flg == 8'h30, "R6 exact match", flg, 8'h30);
    do_read(v);
    sa = 8'h57;
    pulse(0, 1);
    chk(flg == 8'h10, "R6 mismatch", flg, 8'h10);
    do_read(v);
    sa = 8'h56; ha = 8'hC5; hr = 8'h07;
    pulse(0, 1);
    chk(flg == 8'h30, "R6 hour wildcard", flg, 8'h30);
    do_read(v);
    ha = 8'hBF;
    pulse(0, 1);
    chk(flg == 8'h10, "R6 2'b10 not wildcard", flg, 8'h10);
    do_read(v);
  endtask

  task automatic t_allwild;
    logic [7:0] v;
    ha = 8'hFF; ma = 8'hC0; sa = 8'hE3;
    for (int i = 0; i < 3; i++) begin
      sec = 8'(i * 17 + 3);
      pulse(0, 1);
      chk(flg[5] == 1, "R7 every update", flg, 8'h30);
      do_read(v);
    end
  endtask

  task automatic t_set;
    wr_en(3'b111);
    chk(en == 3'b111, "R8 enables written", en, 7);
    setm = 1;
    @(negedge clk);
    chk(en == 3'b110, "R8 set clears uie", en, 6);
    wr_en(3'b111);
    chk(en == 3'b110, "R8 uie held clear", en, 6);
    setm = 0;
    wr_en(3'b000);
  endtask

  task automatic t_reset_mid;
    wr_en(3'b100);
    pulse(1, 1);
    chk(irq == 1, "R10 pre irq", irq, 1);
    rst_n = 0;
    #3;
    chk(flg == 8'h00, "R10 flags cleared", flg, 0);
    chk(en == 3'b000, "R10 en cleared", en, 0);
    chk(irq == 0, "R10 irq released", irq, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_poll();
    t_irq();
    t_late_en();
    t_defer();
    t_alarm();
    t_allwild();
    t_set();
    t_reset_mid();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule